// File: doc/BRIEF.md
# Twenty-One Round Sequencer

This block runs a single round of a simplified twenty-one card game between one player and a dealer. A source outside the block supplies a card value on every cycle. The block takes that value only in a cycle where its own sequence needs a card, and adds it to the player or the dealer hand. The player asks for cards and ends a turn with single-cycle pulses. A separate pulse abandons the round and wipes the running win tallies.

For each hand the block keeps the running total and a blackjack flag and a bust flag. It decides the winner and counts wins for both sides. An ace always counts as one, and card values are expected in the range 1 to 13. The current step of the round is shown as a three-bit code. Downstream logic such as a display or a scoring panel decodes this code, so the encoding is fixed.

Top module: `twentyone_round`

## Requirements
- R1: While `rst_n` is low, `state_o` is 0 and both hand totals and both score counters are 0. Asserting `rst_n` takes effect without a clock edge.
- R2: A `hit_i` pulse in state 0 starts a deal, one card per cycle, in this order. In state 1 and in state 2 the player hand takes `card_i`. In the first cycle of state 3 the dealer hand takes `card_i`.
- R3: State codes: 0 idle, 1 first player card, 2 second player card, 3 dealer card then waiting, 4 player hit, 5 dealer drawing, 6 player won, 7 player lost. `player_win_o` is high only in state 6 and `player_lose_o` is high only in state 7.
- R4: A hand total grows by `card_i` only in a cycle where that hand takes a card. In every other cycle the total holds, whatever value `card_i` carries.
- R5: A hand's blackjack flag is high exactly when its total equals 21. Its bust flag is high exactly when its total exceeds 21. The two flags are never high together.
- R6: In state 3 or 4, once the pending card has been added, a player blackjack moves the round to state 6 and a player bust moves it to state 7. These checks take priority over `hit_i`, `pass_i` and `clear_i`.
- R7: In state 5 the dealer takes one card per cycle while its total is below 17. A dealer bust moves the round to state 6. Otherwise the higher total wins, and a tie moves the round to state 7.
- R8: In state 6 or 7, a `hit_i` pulse returns the block to state 0 and clears both hand totals.
- R9: A `clear_i` pulse in state 3 (after the dealer card), state 4 (after its card) or state 5 returns the block to state 0. It clears both hands and both score counters.
- R10: Entering state 6 adds one to `player_score_o`. Entering state 7 adds one to `dealer_score_o`. Each counter stops at 255.
- R11: A `hit_i` or `pass_i` pulse that arrives in a cycle where a card is being added is ignored. An accepted `hit_i` in state 4 adds exactly one card.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | 1 | Single-cycle request for a card, or start of a new round |
| pass_i | input | 1 | Single-cycle pulse ending the player's turn |
| clear_i | input | 1 | Single-cycle pulse abandoning the round and clearing scores |
| card_i | input | 4 | Card value offered this cycle (1 to 13) |
| state_o | output | 3 | Current round state code |
| player_total_o | output | 8 | Player hand total |
| dealer_total_o | output | 8 | Dealer hand total |
| player_score_o | output | 8 | Player win count |
| dealer_score_o | output | 8 | Dealer win count |
| player_win_o | output | 1 | Player has won this round |
| player_lose_o | output | 1 | Player has lost this round |
| player_bj_o | output | 1 | Player total is exactly 21 |
| player_bust_o | output | 1 | Player total exceeds 21 |
| dealer_bj_o | output | 1 | Dealer total is exactly 21 |
| dealer_bust_o | output | 1 | Dealer total exceeds 21 |

## Verification
Every internal decision of this block shows up at its ports one clock edge later. A wrong state step appears as a wrong `state_o` code on the next cycle. A card added at the wrong moment or to the wrong hand shows up as a wrong total in the same cycle, and then as a wrong win or loss two or three cycles later. A lost or duplicated increment on entering a final state stays in the score counters until `clear_i` is pulsed. The cycle-by-cycle vector walk therefore compares the state, both totals, the flags and both scores after every edge.

// File: rtl/tw_round_pkg.sv
package tw_round_pkg;

  // Downstream logic decodes these codes; the values are fixed.
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PCARD1 = 3'd1,
    ST_PCARD2 = 3'd2,
    ST_DCARD  = 3'd3,
    ST_PHIT   = 3'd4,
    ST_DRAW   = 3'd5,
    ST_WON    = 3'd6,
    ST_LOST   = 3'd7
  } round_st_t;

  localparam int SIDE_PLAYER = 0;
  localparam int SIDE_DEALER = 1;
  localparam int N_SIDES     = 2;

endpackage

// File: rtl/hand_acc.sv
module hand_acc #(
  parameter int CARD_W = 4,
  parameter int TOT_W  = 8,
  parameter int BJ_VAL = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              add_i,
  input  logic [CARD_W-1:0] card_i,
  output logic [TOT_W-1:0]  total_o,
  output logic              bj_o,
  output logic              bust_o
);

  localparam logic [TOT_W-1:0] BJ_V = TOT_W'(BJ_VAL);

  logic [TOT_W-1:0] total_q, total_d;
  logic             total_en;

  always_comb begin
    total_en = clr_i | add_i;
    total_d  = clr_i ? '0 : total_q + {{(TOT_W-CARD_W){1'b0}}, card_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        total_q <= '0;
    else if (total_en) total_q <= total_d;
  end

  assign total_o = total_q;
  assign bj_o    = (total_q == BJ_V);
  assign bust_o  = (total_q >  BJ_V);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!add_i && !clr_i) |=> $stable(total_q));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (total_q == '0));

  p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bj_o && bust_o));

endmodule

// File: rtl/score_ctr.sv
module score_ctr #(
  parameter int SCORE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               inc_i,
  output logic [SCORE_W-1:0] score_o
);

  localparam logic [SCORE_W-1:0] SCORE_MAX = '1;
  localparam logic [SCORE_W-1:0] ONE       = SCORE_W'(1);

  logic [SCORE_W-1:0] cnt_q, cnt_d;
  logic               cnt_en;

  always_comb begin
    cnt_en = clr_i | (inc_i && (cnt_q != SCORE_MAX));
    cnt_d  = clr_i ? '0 : cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign score_o = cnt_q;

  p_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == SCORE_MAX && !clr_i) |=> (cnt_q == SCORE_MAX));

  p_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i && cnt_q != SCORE_MAX) |=> (cnt_q == $past(cnt_q) + ONE));

endmodule

// File: rtl/round_fsm.sv
module round_fsm
  import tw_round_pkg::*;
#(
  parameter int TOT_W     = 8,
  parameter int STAND_VAL = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_i,
  input  logic             pass_i,
  input  logic             clear_i,
  input  logic [TOT_W-1:0] p_tot_i,
  input  logic [TOT_W-1:0] d_tot_i,
  input  logic             p_bj_i,
  input  logic             p_bust_i,
  input  logic             d_bust_i,
  output round_st_t        state_o,
  output logic             p_add_o,
  output logic             d_add_o,
  output logic             hands_clr_o,
  output logic             scores_clr_o,
  output logic             p_inc_o,
  output logic             d_inc_o
);

  localparam logic [TOT_W-1:0] STAND_V = TOT_W'(STAND_VAL);

  round_st_t st_q, st_d;
  logic      settled_q, settled_d;

  always_comb begin
    st_d         = st_q;
    settled_d    = settled_q;
    p_add_o      = 1'b0;
    d_add_o      = 1'b0;
    scores_clr_o = 1'b0;
    unique case (st_q)
      ST_IDLE:   if (hit_i) st_d = ST_PCARD1;
      ST_PCARD1: begin p_add_o = 1'b1; st_d = ST_PCARD2; end
      ST_PCARD2: begin p_add_o = 1'b1; st_d = ST_DCARD;  end
      ST_DCARD: begin
        if (!settled_q) begin
          d_add_o   = 1'b1;
          settled_d = 1'b1;
        end
        else if (p_bj_i)   st_d = ST_WON;
        else if (p_bust_i) st_d = ST_LOST;
        else if (hit_i)    st_d = ST_PHIT;
        else if (pass_i)   st_d = ST_DRAW;
        else if (clear_i) begin
          st_d         = ST_IDLE;
          scores_clr_o = 1'b1;
        end
      end
      ST_PHIT: begin
        if (!settled_q) begin
          p_add_o   = 1'b1;
          settled_d = 1'b1;
        end
        else if (p_bj_i)   st_d = ST_WON;
        else if (p_bust_i) st_d = ST_LOST;
        else if (hit_i)    settled_d = 1'b0;
        else if (pass_i)   st_d = ST_DRAW;
        else if (clear_i) begin
          st_d         = ST_IDLE;
          scores_clr_o = 1'b1;
        end
      end
      ST_DRAW: begin
        if (d_bust_i) st_d = ST_WON;
        else if (clear_i) begin
          st_d         = ST_IDLE;
          scores_clr_o = 1'b1;
        end
        else if (d_tot_i < STAND_V) d_add_o = 1'b1;
        else if (p_tot_i > d_tot_i) st_d = ST_WON;
        else                        st_d = ST_LOST;
      end
      ST_WON, ST_LOST: if (hit_i) st_d = ST_IDLE;
    endcase
    if (st_d != st_q) settled_d = 1'b0;
  end

  always_comb begin
    hands_clr_o = (st_d == ST_IDLE) && (st_q != ST_IDLE);
    p_inc_o     = (st_d == ST_WON)  && (st_q != ST_WON);
    d_inc_o     = (st_d == ST_LOST) && (st_q != ST_LOST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      settled_q <= 1'b0;
    end
    else begin
      st_q      <= st_d;
      settled_q <= settled_d;
    end
  end

  assign state_o = st_q;

  p_deal_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PCARD1) |=> (st_q == ST_PCARD2));

  p_deal_dealer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PCARD2) |=> (st_q == ST_DCARD && d_add_o));

  p_bust_lose_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PHIT && settled_q && p_bust_i) |=> (st_q == ST_LOST));

  p_new_round_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_WON || st_q == ST_LOST) && hit_i) |=> (st_q == ST_IDLE));

  p_stand_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DRAW && !d_bust_i && !clear_i && d_tot_i >= STAND_V)
      |=> (st_q == ST_WON || st_q == ST_LOST));

endmodule

// File: rtl/twentyone_round.sv
module twentyone_round
  import tw_round_pkg::*;
#(
  parameter int CARD_W    = 4,
  parameter int TOT_W     = 8,
  parameter int SCORE_W   = 8,
  parameter int BJ_VAL    = 21,
  parameter int STAND_VAL = 17
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit_i,
  input  logic               pass_i,
  input  logic               clear_i,
  input  logic [CARD_W-1:0]  card_i,
  output logic [2:0]         state_o,
  output logic [TOT_W-1:0]   player_total_o,
  output logic [TOT_W-1:0]   dealer_total_o,
  output logic [SCORE_W-1:0] player_score_o,
  output logic [SCORE_W-1:0] dealer_score_o,
  output logic               player_win_o,
  output logic               player_lose_o,
  output logic               player_bj_o,
  output logic               player_bust_o,
  output logic               dealer_bj_o,
  output logic               dealer_bust_o
);

  // Reset: asserts at once, releases through two flops.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  round_st_t                          st;
  logic [N_SIDES-1:0]                 add_v, inc_v, bj_v, bust_v;
  logic [N_SIDES-1:0][TOT_W-1:0]      tot_v;
  logic [N_SIDES-1:0][SCORE_W-1:0]    score_v;
  logic                               hands_clr, scores_clr;

  round_fsm #(
    .TOT_W     (TOT_W),
    .STAND_VAL (STAND_VAL)
  ) i_fsm (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .hit_i        (hit_i),
    .pass_i       (pass_i),
    .clear_i      (clear_i),
    .p_tot_i      (tot_v[SIDE_PLAYER]),
    .d_tot_i      (tot_v[SIDE_DEALER]),
    .p_bj_i       (bj_v[SIDE_PLAYER]),
    .p_bust_i     (bust_v[SIDE_PLAYER]),
    .d_bust_i     (bust_v[SIDE_DEALER]),
    .state_o      (st),
    .p_add_o      (add_v[SIDE_PLAYER]),
    .d_add_o      (add_v[SIDE_DEALER]),
    .hands_clr_o  (hands_clr),
    .scores_clr_o (scores_clr),
    .p_inc_o      (inc_v[SIDE_PLAYER]),
    .d_inc_o      (inc_v[SIDE_DEALER])
  );

  for (genvar g = 0; g < N_SIDES; g++) begin : g_side
    hand_acc #(
      .CARD_W (CARD_W),
      .TOT_W  (TOT_W),
      .BJ_VAL (BJ_VAL)
    ) i_hand (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .clr_i   (hands_clr),
      .add_i   (add_v[g]),
      .card_i  (card_i),
      .total_o (tot_v[g]),
      .bj_o    (bj_v[g]),
      .bust_o  (bust_v[g])
    );

    score_ctr #(
      .SCORE_W (SCORE_W)
    ) i_score (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .clr_i   (scores_clr),
      .inc_i   (inc_v[g]),
      .score_o (score_v[g])
    );
  end

  assign state_o        = st;
  assign player_total_o = tot_v[SIDE_PLAYER];
  assign dealer_total_o = tot_v[SIDE_DEALER];
  assign player_score_o = score_v[SIDE_PLAYER];
  assign dealer_score_o = score_v[SIDE_DEALER];
  assign player_win_o   = (st == ST_WON);
  assign player_lose_o  = (st == ST_LOST);
  assign player_bj_o    = bj_v[SIDE_PLAYER];
  assign player_bust_o  = bust_v[SIDE_PLAYER];
  assign dealer_bj_o    = bj_v[SIDE_DEALER];
  assign dealer_bust_o  = bust_v[SIDE_DEALER];

  p_one_side_add_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(add_v[SIDE_PLAYER] && add_v[SIDE_DEALER]));

  p_win_lose_excl_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(player_win_o && player_lose_o));

endmodule

// File: tb/test_twentyone_round.sv
module test_twentyone_round;

  typedef struct packed {
    logic       hit;
    logic       pass;
    logic       clr;
    logic [3:0] card;
    logic [2:0] st;
    logic [7:0] pt;
    logic [7:0] dt;
    logic [7:0] ps;
    logic [7:0] ds;
    logic [3:0] fl;   // {player bj, player bust, dealer bj, dealer bust}
  } vec_t;

  localparam int NV = 49;
  localparam vec_t VEC [NV] = '{
    // round A: player stands at 17, dealer draws to 19, player loses
    '{1'b1,1'b0,1'b0,4'd0, 3'd1,8'd0, 8'd0, 8'd0,8'd0,4'b0000},
    '{1'b0,1'b0,1'b0,4'd10,3'd2,8'd10,8'd0, 8'd0,8'd0,4'b0000},
    '{1'b0,1'b0,1'b0,4'd7, 3'd3,8'd17,8'd0, 8'd0,8'd0,4'b0000},
    '{1'b0,1'b0,1'b0,4'd9, 3'd3,8'd17,8'd9, 8'd0,8'd0,4'b0000},
    '{1'b0,1'b0,1'b0,4'd5, 3'd3,8'd17,8'd9, 8'd0,8'd0,4'b0000},
    '{1'b0,1'b1,1'b0,4'd0, 3'd5,8'd17,8'd9, 8'd0,8'd0,4'b0000},
    '{1'b0,1'b0,1'b0,4'd6, 3'd5,8'd17,8'd15,8'd0,8'd0,4'b0000},
    '{1'b0,1'b0,1'b0,4'd4, 3'd5,8'd17,8'd19,8'd0,8'd0,4'b0000},
    '{1'b0,1'b0,1'b0,4'd3, 3'd7,8'd17,8'd19,8'd0,8'd1,4'b0000},
    '{1'b0,1'b0,1'b0,4'd2, 3'd7,8'd17,8'd19,8'd0,8'd1,4'b0000},
    '{1'b1,1'b0,1'b0,4'd0, 3'd0,8'd0, 8'd0, 8'd0,8'd1,4'b0000},
    // round B: player reaches 21 on the deal
    '{1'b1,1'b0,1'b0,4'd0, 3'd1,8'd0, 8'd0, 8'd0,8'd1,4'b0000},
    '{1'b0,1'b0,1'b0,4'd8, 3'd2,8'd8, 8'd0, 8'd0,8'd1,4'b0000},
    '{1'b0,1'b0,1'b0,4'd13,3'd3,8'd21,8'd0, 8'd0,8'd1,4'b1000},
    '{1'b0,1'b0,1'b0,4'd5, 3'd3,8'd21,8'd5, 8'd0,8'd1,4'b1000},
    '{1'b1,1'b0,1'b0,4'd3, 3'd6,8'd21,8'd5, 8'd1,8'd1,4'b1000},
    '{1'b1,1'b0,1'b0,4'd0, 3'd0,8'd0, 8'd0, 8'd1,8'd1,4'b0000},
    // round C: hits, hit pulse during a card ignored, bust
    '{1'b1,1'b0,1'b0,4'd0, 3'd1,8'd0, 8'd0, 8'd1,8'd1,4'b0000},
    '{1'b0,1'b0,1'b0,4'd5, 3'd2,8'd5, 8'd0, 8'd1,8'd1,4'b0000},
    '{1'b0,1'b0,1'b0,4'd6, 3'd3,8'd11,8'd0, 8'd1,8'd1,4'b0000},
    '{1'b0,1'b0,1'b0,4'd10,3'd3,8'd11,8'd10,8'd1,8'd1,4'b0000},
    '{1'b1,1'b0,1'b0,4'd9, 3'd4,8'd11,8'd10,8'd1,8'd1,4'b0000},
    '{1'b1,1'b0,1'b0,4'd4, 3'd4,8'd15,8'd10,8'd1,8'd1,4'b0000},
    '{1'b0,1'b0,1'b0,4'd9, 3'd4,8'd15,8'd10,8'd1,8'd1,4'b0000},
    '{1'b1,1'b0,1'b0,4'd2, 3'd4,8'd15,8'd10,8'd1,8'd1,4'b0000},
    '{1'b0,1'b0,1'b0,4'd12,3'd4,8'd27,8'd10,8'd1,8'd1,4'b0100},
    '{1'b0,1'b0,1'b0,4'd1, 3'd7,8'd27,8'd10,8'd1,8'd2,4'b0100},
    '{1'b1,1'b0,1'b0,4'd0, 3'd0,8'd0, 8'd0, 8'd1,8'd2,4'b0000},
    // round D: clear pulse while waiting
    '{1'b1,1'b0,1'b0,4'd0, 3'd1,8'd0, 8'd0, 8'd1,8'd2,4'b0000},
    '{1'b0,1'b0,1'b0,4'd3, 3'd2,8'd3, 8'd0, 8'd1,8'd2,4'b0000},
    '{1'b0,1'b0,1'b0,4'd4, 3'd3,8'd7, 8'd0, 8'd1,8'd2,4'b0000},
    '{1'b0,1'b0,1'b0,4'd2, 3'd3,8'd7, 8'd2, 8'd1,8'd2,4'b0000},
    '{1'b0,1'b0,1'b1,4'd0, 3'd0,8'd0, 8'd0, 8'd0,8'd0,4'b0000},
    // round E: dealer busts
    '{1'b1,1'b0,1'b0,4'd0, 3'd1,8'd0, 8'd0, 8'd0,8'd0,4'b0000},
    '{1'b0,1'b0,1'b0,4'd10,3'd2,8'd10,8'd0, 8'd0,8'd0,4'b0000},
    '{1'b0,1'b0,1'b0,4'd9, 3'd3,8'd19,8'd0, 8'd0,8'd0,4'b0000},
    '{1'b0,1'b0,1'b0,4'd6, 3'd3,8'd19,8'd6, 8'd0,8'd0,4'b0000},
    '{1'b0,1'b1,1'b0,4'd0, 3'd5,8'd19,8'd6, 8'd0,8'd0,4'b0000},
    '{1'b0,1'b0,1'b0,4'd10,3'd5,8'd19,8'd16,8'd0,8'd0,4'b0000},
    '{1'b0,1'b0,1'b0,4'd10,3'd5,8'd19,8'd26,8'd0,8'd0,4'b0001},
    '{1'b0,1'b0,1'b0,4'd1, 3'd6,8'd19,8'd26,8'd1,8'd0,4'b0001},
    // round F: equal totals, counted as a player loss
    '{1'b1,1'b0,1'b0,4'd0, 3'd0,8'd0, 8'd0, 8'd1,8'd0,4'b0000},
    '{1'b1,1'b0,1'b0,4'd0, 3'd1,8'd0, 8'd0, 8'd1,8'd0,4'b0000},
    '{1'b0,1'b0,1'b0,4'd10,3'd2,8'd10,8'd0, 8'd1,8'd0,4'b0000},
    '{1'b0,1'b0,1'b0,4'd7, 3'd3,8'd17,8'd0, 8'd1,8'd0,4'b0000},
    '{1'b0,1'b0,1'b0,4'd10,3'd3,8'd17,8'd10,8'd1,8'd0,4'b0000},
    '{1'b0,1'b1,1'b0,4'd0, 3'd5,8'd17,8'd10,8'd1,8'd0,4'b0000},
    '{1'b0,1'b0,1'b0,4'd7, 3'd5,8'd17,8'd17,8'd1,8'd0,4'b0000},
    '{1'b0,1'b0,1'b0,4'd0, 3'd7,8'd17,8'd17,8'd1,8'd1,4'b0000}
  };

  logic       clk, rst_n, hit, pass, clr;
  logic [3:0] card;
  logic [2:0] st;
  logic [7:0] pt, dt, ps, ds;
  logic       win, lose, pbj, pbust, dbj, dbust;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  twentyone_round i_twentyone_round (
    .clk            (clk),
    .rst_n          (rst_n),
    .hit_i          (hit),
    .pass_i         (pass),
    .clear_i        (clr),
    .card_i         (card),
    .state_o        (st),
    .player_total_o (pt),
    .dealer_total_o (dt),
    .player_score_o (ps),
    .dealer_score_o (ds),
    .player_win_o   (win),
    .player_lose_o  (lose),
    .player_bj_o    (pbj),
    .player_bust_o  (pbust),
    .dealer_bj_o    (dbj),
    .dealer_bust_o  (dbust)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", what, act, exp, $time);
    end
  endtask

  task automatic drive(input logic h, input logic p, input logic c, input logic [3:0] cd);
    hit = h; pass = p; clr = c; card = cd;
  endtask

  task automatic cycle(input logic h, input logic p, input logic c, input logic [3:0] cd);
    drive(h, p, c, cd);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b0, 1'b0, 1'b0, 4'd0);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset state",       st, 0);
    chk("R1 reset player total", pt, 0);
    chk("R1 reset dealer total", dt, 0);
    chk("R1 reset scores",       ps + ds, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Vector walk: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11
    for (int i = 0; i < NV; i++) begin
      cycle(VEC[i].hit, VEC[i].pass, VEC[i].clr, VEC[i].card);
      chk($sformatf("R2/R3 v%0d state", i), st, VEC[i].st);
      chk($sformatf("R4 v%0d player total", i), pt, VEC[i].pt);
      chk($sformatf("R4/R7 v%0d dealer total", i), dt, VEC[i].dt);
      chk($sformatf("R10/R9 v%0d player score", i), ps, VEC[i].ps);
      chk($sformatf("R10/R9 v%0d dealer score", i), ds, VEC[i].ds);
      chk($sformatf("R5 v%0d flags", i), {pbj, pbust, dbj, dbust}, VEC[i].fl);
      chk($sformatf("R3 v%0d win flag", i), win, (VEC[i].st == 3'd6));
      chk($sformatf("R3 v%0d lose flag", i), lose, (VEC[i].st == 3'd7));
    end

    // R10: player score saturates at 255 over many blackjack rounds
    for (int r = 0; r < 256; r++) begin
      cycle(1'b1, 1'b0, 1'b0, 4'd0);   // back to idle
      cycle(1'b1, 1'b0, 1'b0, 4'd0);   // start deal
      cycle(1'b0, 1'b0, 1'b0, 4'd10);
      cycle(1'b0, 1'b0, 1'b0, 4'd11);
      cycle(1'b0, 1'b0, 1'b0, 4'd2);   // dealer card
      cycle(1'b0, 1'b0, 1'b0, 4'd0);   // blackjack win
    end
    chk("R10 saturated state", st, 6);
    chk("R10 saturated player score", ps, 255);
    chk("R10 dealer score untouched", ds, 1);
    cycle(1'b1, 1'b0, 1'b0, 4'd0);
    chk("R10 score held at limit", ps, 255);

    // R11: pass during a player card is ignored
    cycle(1'b1, 1'b0, 1'b0, 4'd0);
    cycle(1'b0, 1'b1, 1'b0, 4'd4);
    cycle(1'b0, 1'b1, 1'b0, 4'd5);
    chk("R11 pass ignored in deal", st, 3);
    chk("R11 player total after deal", pt, 9);

    // R1: asynchronous reset mid-round
    cycle(1'b0, 1'b0, 1'b0, 4'd3);
    chk("R2 dealer card", dt, 3);
    #2 rst_n = 1'b0;
    #1;
    chk("R1 async state", st, 0);
    chk("R1 async totals", pt + dt, 0);
    chk("R1 async scores", ps + ds, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule